// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block is the interrupt control unit of a small 16-bit segmented processor. At each instruction boundary (`step`) it looks at a maskable request line, a non-maskable event input, a software-interrupt request with its type number, and a return-from-interrupt request. It picks one of them. For a maskable request it first raises `ack` for one cycle and reads the type number from `ack_data`. It then runs the entry sequence over a single-word request/ready bus. The sequence pushes the flag word, CS and IP onto the stack, reads the offset and segment words of the vector, and loads the new CS:IP.

A return request reverses this. It pops IP, CS and the flag word, and restores the interrupt-enable flag from bit 9 of the popped word. The enable flag is owned here: instruction-boundary clear/set commands change it, and the entry sequence clears it. The rest of the core stalls while `busy` is high and supplies the next IP and its other flag bits.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset CS is 0xFFFF, IP is 0x0000, SP is 0x0100, the enable flag `ie` is 0, nothing is pending, and `busy`, `ack` and `bus_req` are low.
- R2: Requests act only at an idle-cycle `step`, which also loads `step_ip` into IP. An `nmi_req` pulse between boundaries is held pending until the next `step`.
- R3: While `ie` is 0, `mreq` has no effect. Non-maskable and software requests are taken whatever the value of `ie`.
- R4: `cli_cmd` (clears) and `sti_cmd` (sets) update `ie` at a `step`, with clear winning if both are set. The choice made at that same step uses the old value of `ie`.
- R5: A maskable request that is accepted raises `ack` for exactly the one cycle after its `step`. In that cycle the type is taken from `ack_data`.
- R6: Selection order is return, then non-maskable, then software, then maskable. A non-maskable or software request that loses stays pending and is taken at a later step.
- R7: Entry writes the flag word, then CS, then IP. SP drops by 2 before each write, and the stack address is 0x08000 + SP.
- R8: The pushed flag word equals `cpu_flags` with bit 9 replaced by the current `ie`.
- R9: `ie` becomes 0 once the flag-word write has completed.
- R10: For type n, the offset word is read at 4n and loaded into IP, then the segment word is read at 4n+2 and loaded into CS. The non-maskable type is 2, so its vector starts at 0x00008.
- R11: Return reads IP, CS and then the flag word from 0x08000 + SP, adding 2 to SP after each read. `ie` takes bit 9 of the flag word. `rest_valid` pulses with that word on `rest_flags`.
- R12: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until `bus_rdy`. One word moves in each cycle in which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Instruction boundary |
| step_ip | input | 16 | IP of the next instruction |
| cpu_flags | input | 16 | Flag word from the core (bit 9 replaced here) |
| iret_req | input | 1 | Return-from-interrupt at this boundary |
| cli_cmd | input | 1 | Clear enable at this boundary |
| sti_cmd | input | 1 | Set enable at this boundary |
| mreq | input | 1 | Maskable request level |
| nmi_req | input | 1 | Non-maskable event pulse |
| sw_req | input | 1 | Software interrupt at this boundary |
| sw_type | input | 8 | Software interrupt type |
| ack_data | input | 8 | Type number supplied during acknowledge |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Bus transfer completes |
| busy | output | 1 | Sequence in progress |
| ack | output | 1 | Interrupt acknowledge |
| ie | output | 1 | Interrupt-enable flag |
| cs | output | 16 | Code segment |
| ip | output | 16 | Instruction pointer |
| sp | output | 16 | Stack pointer |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Write when high |
| bus_addr | output | 20 | Physical word address |
| bus_wdata | output | 16 | Write data |
| rest_flags | output | 16 | Restored flag word |
| rest_valid | output | 1 | `rest_flags` is valid |

## Verification
The assertions check these rules on every cycle: the bus holds steady during wait states, SP moves by exactly 2 on each push, `ack` is a single cycle that follows a step with `mreq`, `busy` starts only at a step, and `ie` changes only through a command, a flag push or a restore. Some properties can only be shown by the bench scenarios. These are the order of selection among requests that arrive together, pending requests that survive a lost choice or a pulse between boundaries, the one-step delay of a set-enable, and the exact contents and order of the stack frame and the vector reads. A nested pair of entries followed by two returns confirms that the enable flag comes back correctly at each level.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter logic [15:0] RST_CS  = 16'hFFFF,
  parameter logic [15:0] RST_IP  = 16'h0000,
  parameter logic [15:0] RST_SP  = 16'h0100,
  parameter logic [15:0] STK_SEG = 16'h0800,
  parameter logic [7:0]  NMI_TYP = 8'd2,
  parameter int          IE_BIT  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [15:0] step_ip,
  input  logic [15:0] cpu_flags,
  input  logic        iret_req,
  input  logic        cli_cmd,
  input  logic        sti_cmd,
  input  logic        mreq,
  input  logic        nmi_req,
  input  logic        sw_req,
  input  logic [7:0]  sw_type,
  input  logic [7:0]  ack_data,
  input  logic [15:0] bus_rdata,
  input  logic        bus_rdy,
  output logic        busy,
  output logic        ack,
  output logic        ie,
  output logic [15:0] cs,
  output logic [15:0] ip,
  output logic [15:0] sp,
  output logic        bus_req,
  output logic        bus_we,
  output logic [19:0] bus_addr,
  output logic [15:0] bus_wdata,
  output logic [15:0] rest_flags,
  output logic        rest_valid
);

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_PF, S_PC, S_PI, S_VO, S_VS, S_RI, S_RC, S_RF
  } st_t;

  st_t        st;
  logic [7:0] typ, sw_t;
  logic       nmi_p, sw_p;

  wire go       = (st == S_IDLE) && step;
  wire nmi_e    = nmi_p || nmi_req;
  wire sw_e     = sw_p || sw_req;
  wire [7:0] swt_e = sw_req ? sw_type : sw_t;
  wire take_ret = go && iret_req;
  wire take_nmi = go && !iret_req && nmi_e;
  wire take_sw  = go && !iret_req && !nmi_e && sw_e;
  wire take_m   = go && !iret_req && !nmi_e && !sw_e && mreq && ie;
  wire vec      = (st == S_VO) || (st == S_VS);

  assign busy    = (st != S_IDLE);
  assign ack     = (st == S_ACK);
  assign bus_req = busy && (st != S_ACK);
  assign bus_we  = (st == S_PF) || (st == S_PC) || (st == S_PI);

  wire [15:0] stk_off = bus_we ? sp - 16'd2 : sp;
  assign bus_addr = vec ? {10'd0, typ, (st == S_VS), 1'b0}
                        : ({STK_SEG, 4'h0} + {4'h0, stk_off});

  logic [15:0] fl_word;
  always_comb begin
    fl_word         = cpu_flags;
    fl_word[IE_BIT] = ie;
  end

  assign bus_wdata  = (st == S_PF) ? fl_word : (st == S_PC) ? cs : ip;
  assign rest_flags = bus_rdata;
  assign rest_valid = (st == S_RF) && bus_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs <= RST_CS; ip <= RST_IP; sp <= RST_SP;
      typ <= '0; sw_t <= '0; nmi_p <= 1'b0; sw_p <= 1'b0;
    end else begin
      if (nmi_req) nmi_p <= 1'b1;
      case (st)
        S_IDLE: if (step) begin
          ip <= step_ip;
          if (take_ret) st <= S_RI;
          else if (take_nmi) begin st <= S_PF; typ <= NMI_TYP; nmi_p <= 1'b0; end
          else if (take_sw) begin st <= S_PF; typ <= swt_e; sw_p <= 1'b0; end
          else if (take_m) st <= S_ACK;
          if (sw_req && !take_sw) begin sw_p <= 1'b1; sw_t <= sw_type; end
        end
        S_ACK: begin typ <= ack_data; st <= S_PF; end
        S_PF:  if (bus_rdy) begin sp <= sp - 16'd2; st <= S_PC; end
        S_PC:  if (bus_rdy) begin sp <= sp - 16'd2; st <= S_PI; end
        S_PI:  if (bus_rdy) begin sp <= sp - 16'd2; st <= S_VO; end
        S_VO:  if (bus_rdy) begin ip <= bus_rdata; st <= S_VS; end
        S_VS:  if (bus_rdy) begin cs <= bus_rdata; st <= S_IDLE; end
        S_RI:  if (bus_rdy) begin ip <= bus_rdata; sp <= sp + 16'd2; st <= S_RC; end
        S_RC:  if (bus_rdy) begin cs <= bus_rdata; sp <= sp + 16'd2; st <= S_RF; end
        S_RF:  if (bus_rdy) begin sp <= sp + 16'd2; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ie <= 1'b0;
    else if (rest_valid)             ie <= bus_rdata[IE_BIT];
    else if (st == S_PF && bus_rdy)  ie <= 1'b0;
    else if (go && cli_cmd)          ie <= 1'b0;
    else if (go && sti_cmd)          ie <= 1'b1;
  end

endmodule

module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic        mreq,
  input logic        cli_cmd,
  input logic        sti_cmd,
  input logic        busy,
  input logic        ack,
  input logic        ie,
  input logic [15:0] sp,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_rdy,
  input logic [19:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        rest_valid
);

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R7
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_rdy |=> sp == $past(sp) - 16'd2);

  // R5
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(step && mreq) && !bus_req);

  // R5
  ack_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(step));

  // R4
  ie_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie) |-> $past(step && sti_cmd) || $past(rest_valid));

  // R9
  ie_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> $past(step && cli_cmd) || $past(bus_req && bus_we && bus_rdy) || $past(rest_valid));

endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .mreq(mreq), .cli_cmd(cli_cmd),
  .sti_cmd(sti_cmd), .busy(busy), .ack(ack), .ie(ie), .sp(sp),
  .bus_req(bus_req), .bus_we(bus_we), .bus_rdy(bus_rdy), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rest_valid(rest_valid)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;

  localparam logic [15:0] FLG = 16'h0ED5;
  localparam int STK = 32'h08000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 0, iret_req = 0, cli_cmd = 0, sti_cmd = 0, mreq = 0, nmi_req = 0, sw_req = 0;
  logic [15:0] step_ip = 0, cpu_flags = FLG, bus_rdata = 0;
  logic [7:0] sw_type = 0, ack_data = 0;
  logic bus_rdy, busy, ack, ie, bus_req, bus_we, rest_valid;
  logic [15:0] cs, ip, sp, bus_wdata, rest_flags;
  logic [19:0] bus_addr;

  always #5 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .step_ip(step_ip), .cpu_flags(cpu_flags),
    .iret_req(iret_req), .cli_cmd(cli_cmd), .sti_cmd(sti_cmd), .mreq(mreq),
    .nmi_req(nmi_req), .sw_req(sw_req), .sw_type(sw_type), .ack_data(ack_data),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .busy(busy), .ack(ack), .ie(ie),
    .cs(cs), .ip(ip), .sp(sp), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rest_flags(rest_flags),
    .rest_valid(rest_valid)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory with wait states
  logic [15:0] mem [int];
  int wcnt = 1;
  bit wsel = 0;
  assign bus_rdy = bus_req && (wcnt == 0);

  always @(posedge clk) begin
    if (bus_req && bus_rdy) begin
      if (bus_we) mem[int'(bus_addr)] = bus_wdata;
      wsel <= !wsel;
      wcnt <= wsel ? 2 : 0;
    end else if (bus_req && wcnt != 0) wcnt <= wcnt - 1;
  end

  always @(negedge clk)
    bus_rdata = mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : 16'h0000;

  // expected bus traffic
  bit    q_we[$];
  int    q_addr[$];
  int    q_data[$];
  string q_tag[$];
  int m_cs, m_ip, m_sp;
  bit m_ie, m_nmi, m_sw;
  int m_swt;
  int fr_f[$], fr_c[$], fr_i[$];
  int exp_rest;

  always @(negedge clk) begin
    if (rst_n && bus_req && bus_rdy) begin
      if (q_we.size() == 0) chk("R12 unexpected transfer", bus_addr, 32'hFFFFFFFF);
      else begin
        string t;
        bit w; int a, d;
        t = q_tag.pop_front(); w = q_we.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
        chk({t, " dir"}, bus_we, w);
        chk({t, " addr"}, bus_addr, a);
        if (w) chk({t, " data"}, bus_wdata, d);
      end
    end
    if (rst_n && rest_valid) chk("R11 rest_flags", rest_flags, exp_rest);
  end

  function automatic int voff(int t); return 16'h1000 + t; endfunction
  function automatic int vseg(int t); return 16'h2000 + t; endfunction

  task automatic model_entry(input int t);
    int fw;
    fw = (FLG & ~32'h200) | (int'(m_ie) << 9);
    q_tag.push_back("R8");  q_we.push_back(1); q_addr.push_back(STK + m_sp - 2); q_data.push_back(fw);
    q_tag.push_back("R7");  q_we.push_back(1); q_addr.push_back(STK + m_sp - 4); q_data.push_back(m_cs);
    q_tag.push_back("R7");  q_we.push_back(1); q_addr.push_back(STK + m_sp - 6); q_data.push_back(m_ip);
    q_tag.push_back("R10"); q_we.push_back(0); q_addr.push_back(4 * t);         q_data.push_back(0);
    q_tag.push_back("R10"); q_we.push_back(0); q_addr.push_back(4 * t + 2);     q_data.push_back(0);
    fr_f.push_back(fw); fr_c.push_back(m_cs); fr_i.push_back(m_ip);
    m_sp = (m_sp - 6) & 16'hFFFF; m_ie = 0; m_cs = vseg(t); m_ip = voff(t);
  endtask

  task automatic model_ret();
    int fw;
    q_tag.push_back("R11"); q_we.push_back(0); q_addr.push_back(STK + m_sp);     q_data.push_back(0);
    q_tag.push_back("R11"); q_we.push_back(0); q_addr.push_back(STK + m_sp + 2); q_data.push_back(0);
    q_tag.push_back("R11"); q_we.push_back(0); q_addr.push_back(STK + m_sp + 4); q_data.push_back(0);
    fw = fr_f.pop_back(); m_cs = fr_c.pop_back(); m_ip = fr_i.pop_back();
    exp_rest = fw; m_ie = fw[9]; m_sp = (m_sp + 6) & 16'hFFFF;
  endtask

  task automatic do_step(input string tag, input int nip, input bit ir, input bit nm,
                         input bit sw, input int swty, input bit mr, input bit cl,
                         input bit stc, input int atype);
    bit old_ie, nmi_e, sw_e, taken, eack;
    int swt;
    @(negedge clk);
    step = 1; step_ip = nip[15:0]; iret_req = ir; nmi_req = nm; sw_req = sw;
    sw_type = swty[7:0]; mreq = mr; cli_cmd = cl; sti_cmd = stc; ack_data = atype[7:0];
    nmi_e = m_nmi | nm; sw_e = m_sw | sw; swt = sw ? swty : m_swt;
    if (sw) m_swt = swty;
    old_ie = m_ie; m_ip = nip;
    if (cl) m_ie = 0; else if (stc) m_ie = 1;
    taken = 1; eack = 0;
    if (ir) begin m_nmi = nmi_e; m_sw = sw_e; model_ret(); end
    else if (nmi_e) begin m_nmi = 0; m_sw = sw_e; model_entry(2); end
    else if (sw_e) begin m_sw = 0; model_entry(swt); end
    else if (mr && old_ie) begin eack = 1; model_entry(atype); end
    else begin taken = 0; m_nmi = nmi_e; m_sw = sw_e; end
    @(negedge clk);
    step = 0; iret_req = 0; nmi_req = 0; sw_req = 0; mreq = 0; cli_cmd = 0; sti_cmd = 0;
    chk({tag, " busy"}, busy, taken);
    chk("R5 ack", ack, eack);
    while (busy) @(negedge clk);
    chk({tag, " queue drained"}, q_we.size(), 0);
    chk({tag, " cs"}, cs, m_cs);
    chk({tag, " ip"}, ip, m_ip);
    chk({tag, " sp"}, sp, m_sp);
    chk({tag, " ie"}, ie, m_ie);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (mem[k]) mem.delete(k);
    for (int n = 0; n < 256; n++) begin
      mem[4 * n] = voff(n);
      mem[4 * n + 2] = vseg(n);
    end
    m_cs = 16'hFFFF; m_ip = 0; m_sp = 16'h0100; m_ie = 0; m_nmi = 0; m_sw = 0; m_swt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1 cs", cs, 16'hFFFF); chk("R1 ip", ip, 0); chk("R1 sp", sp, 16'h0100);
    chk("R1 ie", ie, 0); chk("R1 busy", busy, 0); chk("R1 ack", ack, 0); chk("R1 bus_req", bus_req, 0);

    // masked request ignored, software and nmi still taken
    do_step("R3 masked",   16'h0010, 0,0,0,0,   1,0,0, 8'h21);
    do_step("R3 sw",       16'h0012, 0,0,1,8'h40,0,0,0, 0);
    do_step("R11 ret",     16'h0100, 1,0,0,0,   0,0,0, 0);
    do_step("R10 nmi",     16'h0014, 0,1,0,0,   0,0,0, 0);
    do_step("R11 ret",     16'h0102, 1,0,0,0,   0,0,0, 0);

    // set-enable with request at same step: not taken yet
    do_step("R4 sti",      16'h0016, 0,0,0,0,   1,0,1, 8'h21);
    do_step("R5 mask",     16'h0018, 0,0,0,0,   1,0,0, 8'h21);
    do_step("R11 ret ie",  16'h0104, 1,0,0,0,   0,0,0, 0);

    // simultaneous requests
    do_step("R6 all",      16'h001A, 0,1,1,8'h30,1,0,0, 8'h31);
    do_step("R6 sw pend",  16'h1004, 0,0,0,0,   0,0,0, 0);
    do_step("R11 ret sw",  16'h1032, 1,0,0,0,   0,0,0, 0);
    do_step("R11 ret nmi", 16'h1006, 1,0,0,0,   0,0,0, 0);
    do_step("R5 mask2",    16'h001C, 0,0,0,0,   1,0,0, 8'h31);
    do_step("R11 ret",     16'h1033, 1,0,0,0,   0,0,0, 0);

    // clear-enable blocks later masked request
    do_step("R4 cli",      16'h001E, 0,0,0,0,   0,1,0, 0);
    do_step("R3 masked2",  16'h0020, 0,0,0,0,   1,0,0, 8'h21);

    // nmi pulse between boundaries stays pending
    @(negedge clk) nmi_req = 1;
    m_nmi = 1;
    @(negedge clk) nmi_req = 0;
    repeat (3) @(negedge clk);
    chk("R2 no action between steps", busy, 0);
    do_step("R2 nmi pend", 16'h0022, 0,0,0,0,   0,0,0, 0);
    do_step("R11 ret",     16'h0106, 1,0,0,0,   0,0,0, 0);

    // return beats non-maskable
    do_step("R6 sw",       16'h0024, 0,0,1,8'h40,0,0,0, 0);
    do_step("R6 ret first",16'h1044, 1,1,0,0,   0,0,0, 0);
    do_step("R6 nmi after",16'h0026, 0,0,0,0,   0,0,0, 0);
    do_step("R11 ret",     16'h1006, 1,0,0,0,   0,0,0, 0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule